// File: doc/BRIEF.md
# Outbound Mailbox Channel Dispatcher

This block takes 32-bit message words written by a host and hands each one to one of several channel endpoints. The low four bits of every word name the target channel. When that endpoint is idle, the block forwards the complete word to it one cycle after the write. When the endpoint reports busy, the word is parked in a small holding FIFO. A word that names a channel that does not exist is dropped, and so is any word that arrives while the FIFO is full. Each drop raises a sticky flag.

The host can read two registers: a FIFO status word with full, empty and fill-level fields, and the drop flag. Any write to the drop-flag address clears the flag. Words in the holding FIFO are never drained onward. They stay until reset, and the fill level shows how many are parked.

Top module: `mbox_out_dispatch`

## Requirements
- R1: After reset the status word reads 0x40000000 (empty, level 0), the drop flag reads 0, and no endpoint strobe is active.
- R2: A write is a submission only when its byte address lies in 0xA0..0xAC inclusive. A write to any other address submits nothing, so no strobe fires and the level does not change.
- R3: A submission whose channel (bits 3:0) is below 9, whose endpoint busy input is low, and which arrives while the FIFO is not full raises ep_valid bit [channel] for exactly one cycle, starting on the cycle after the write. ep_data then carries the whole 32-bit word, channel bits included.
- R4: A submission whose selected endpoint is busy, and which arrives while the FIFO is not full, is stored. The fill level rises by one and no strobe fires.
- R5: A submission whose channel is 9..15 is discarded: no strobe, no change to the level, and the drop flag becomes 1.
- R6: A submission that arrives while the FIFO holds 8 words is discarded whatever its channel or busy state, and the drop flag becomes 1.
- R7: A read at 0xB8 returns bit 31 = full (level 8), bit 30 = empty (level 0), bits 7:0 = level, and all other bits 0.
- R8: A read at 0xBC returns the drop flag in bit 0, with all other bits 0. Any write to 0xBC clears the flag.
- R9: Stored words are never removed. The level holds across any later busy pattern until reset, which returns it to 0 and refills every slot with 0xFFFFFFFF.
- R10: A read at any address other than 0xB8 or 0xBC returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 8 | Host write byte address |
| wr_data | input | 32 | Host write data |
| rd_addr | input | 8 | Host read byte address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| ep_busy | input | 9 | Per-channel endpoint busy |
| ep_valid | output | 9 | Per-channel one-cycle delivery strobe |
| ep_data | output | 32 | Delivered word, shared by all channels |

## Verification
The hardest case to reach is a drop on a full FIFO. Eight submissions have to land on busy endpoints with valid channels before the ninth can be rejected for being full, and a random mix of busy inputs and channel numbers seldom lines that up. The stimulus therefore includes a directed fill: every channel is held busy, eight valid words are written, and then a further word is written to an idle, in-range channel. That word must still be dropped. Random phases hold most busy bits high, with periodic resets, so that the full boundary is crossed many times from different mixes of writes.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic [1:0] {
    RT_NONE = 2'd0,
    RT_FWD  = 2'd1,
    RT_HOLD = 2'd2,
    RT_DROP = 2'd3
  } route_e;

  localparam logic [7:0] SUB_LO   = 8'hA0;
  localparam logic [7:0] SUB_HI   = 8'hAC;
  localparam logic [7:0] STAT_ADR = 8'hB8;
  localparam logic [7:0] DROP_ADR = 8'hBC;

  function automatic logic in_submit_window(input logic [7:0] a);
    return (a >= SUB_LO) && (a <= SUB_HI);
  endfunction

  function automatic logic [31:0] status_word(input int unsigned level,
                                              input int unsigned depth);
    logic [31:0] w;
    w = '0;
    w[31] = (level == depth);
    w[30] = (level == 0);
    w[7:0] = level[7:0];
    return w;
  endfunction

endpackage

// File: rtl/mbox_wr_decode.sv
module mbox_wr_decode
  import mbox_pkg::*;
(
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  output logic       submit,
  output logic       clr_drop
);
  always_comb begin
    submit   = wr_en && in_submit_window(wr_addr);
    clr_drop = wr_en && (wr_addr == DROP_ADR);
  end
endmodule

// File: rtl/mbox_route.sv
module mbox_route
  import mbox_pkg::*;
#(
  parameter int NUM_CH = 9,
  parameter int CH_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              submit,
  input  logic [CH_W-1:0]   ch,
  input  logic [NUM_CH-1:0] busy,
  input  logic              fifo_full,
  output route_e            route,
  output logic              ch_ok
);
  logic busy_sel;

  always_comb begin
    busy_sel = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (int'(ch) == i) busy_sel = busy[i];
    end
    ch_ok = (int'(ch) < NUM_CH);
  end

  always_comb begin
    route = RT_NONE;
    if (submit) begin
      if (fifo_full)      route = RT_DROP;
      else if (!ch_ok)    route = RT_DROP;
      else if (busy_sel)  route = RT_HOLD;
      else                route = RT_FWD;
    end
  end

  // R6
  hold_never_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route == RT_HOLD) |-> !fifo_full);
  // R5
  bad_ch_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (submit && !ch_ok) |-> (route == RT_DROP));
endmodule

// File: rtl/mbox_hold_fifo.sv
module mbox_hold_fifo #(
  parameter int          DEPTH   = 8,
  parameter int          W       = 32,
  parameter logic [W-1:0] INVALID = '1,
  localparam int         CW      = $clog2(DEPTH + 1),
  localparam int         IW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0] slot [DEPTH];
  logic [IW-1:0] wr_idx;

  assign wr_idx = level[IW-1:0];
  assign full   = (int'(level) == DEPTH);
  assign empty  = (level == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)               level <= '0;
    else if (push && !full)   level <= level + 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                  slot[g] <= INVALID;
      else if (push && !full && int'(wr_idx) == g) slot[g] <= din;
    end
    // R9
    unused_slot_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(level) <= g) |-> (slot[g] == INVALID));
  end

  // R9
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= DEPTH);
  // R9
  no_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !push |=> $stable(level));
endmodule

// File: rtl/mbox_out_dispatch.sv
module mbox_out_dispatch
  import mbox_pkg::*;
#(
  parameter int          NUM_CH  = 9,
  parameter int          DEPTH   = 8,
  parameter int          W       = 32,
  parameter logic [W-1:0] INVALID = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [7:0]        rd_addr,
  output logic [W-1:0]      rd_data,
  input  logic [NUM_CH-1:0] ep_busy,
  output logic [NUM_CH-1:0] ep_valid,
  output logic [W-1:0]      ep_data
);
  localparam int CH_W = 4;
  localparam int CW   = $clog2(DEPTH + 1);

  logic          submit, clr_drop, ch_ok;
  logic          fifo_full, fifo_empty;
  logic [CW-1:0] level;
  logic          drop_flag;
  route_e        route;
  logic          ev_fwd, ev_hold, ev_drop;

  mbox_wr_decode u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .submit  (submit),
    .clr_drop(clr_drop)
  );

  mbox_route #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .submit   (submit),
    .ch       (wr_data[CH_W-1:0]),
    .busy     (ep_busy),
    .fifo_full(fifo_full),
    .route    (route),
    .ch_ok    (ch_ok)
  );

  assign ev_fwd  = (route == RT_FWD);
  assign ev_hold = (route == RT_HOLD);
  assign ev_drop = (route == RT_DROP);

  mbox_hold_fifo #(.DEPTH(DEPTH), .W(W), .INVALID(INVALID)) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .push (ev_hold),
    .din  (wr_data),
    .level(level),
    .full (fifo_full),
    .empty(fifo_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        drop_flag <= 1'b0;
    else if (ev_drop)  drop_flag <= 1'b1;
    else if (clr_drop) drop_flag <= 1'b0;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ep
    always_ff @(posedge clk) begin
      if (!rst_n) ep_valid[c] <= 1'b0;
      else        ep_valid[c] <= ev_fwd && (int'(wr_data[CH_W-1:0]) == c);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ep_data <= '0;
    else if (ev_fwd) ep_data <= wr_data;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == STAT_ADR)      rd_data = status_word(int'(level), DEPTH);
    else if (rd_addr == DROP_ADR) rd_data[0] = drop_flag;
  end

  // R3
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ep_valid));
  // R3
  fwd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fwd |=> ($countones(ep_valid) == 1) && (ep_data == $past(wr_data)));
  // R5
  drop_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> drop_flag);
  // R2
  no_submit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !submit |=> (ep_valid == '0) && $stable(level));
  // R7
  empty_full_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty) && (ch_ok || !ev_fwd));
endmodule

// File: tb/mbox_out_dispatch_test.sv
module mbox_out_dispatch_test;
  localparam int NCH = 9;
  localparam int DEP = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;
  logic [7:0]  rd_addr;
  logic [31:0] rd_data;
  logic [NCH-1:0] ep_busy;
  logic [NCH-1:0] ep_valid;
  logic [31:0] ep_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  int m_level;
  bit m_drop;

  always #2.5 clk = ~clk;

  mbox_out_dispatch uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ep_busy(ep_busy), .ep_valid(ep_valid), .ep_data(ep_data)
  );

  function automatic logic [31:0] exp_status(input int lvl);
    logic [31:0] v;
    v = 32'd0;
    if (lvl >= DEP) v = v | 32'h8000_0000;
    if (lvl == 0)   v = v | 32'h4000_0000;
    v = v | (lvl & 8'hFF);
    return v;
  endfunction

  function automatic bit is_sub(input logic [7:0] a);
    return a inside {[8'hA0:8'hAC]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic [7:0] a, output logic [31:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic check_regs(input string req);
    logic [31:0] v;
    read_reg(8'hB8, v);
    check({req, " status"}, v, exp_status(m_level));
    read_reg(8'hBC, v);
    check({req, " drop"}, v, {31'd0, m_drop});
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_level = 0; m_drop = 0;
  endtask

  // one write, then checks of strobe, data and registers at the next negedge
  task automatic do_write(input string req, input logic [7:0] a,
                          input logic [31:0] d, input logic [NCH-1:0] busy);
    logic [NCH-1:0] exp_v;
    int ch;
    exp_v = '0;
    ch = int'(d[3:0]);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; ep_busy = busy;
    if (is_sub(a)) begin
      if (m_level >= DEP || ch >= NCH) m_drop = 1;
      else if (busy[ch]) m_level++;
      else exp_v[ch] = 1'b1;
    end else if (a == 8'hBC) begin
      m_drop = 0;
    end
    @(negedge clk);
    wr_en = 1'b0;
    check({req, " strobe"}, 32'(ep_valid), 32'(exp_v));
    if (exp_v != '0) check({req, " data"}, ep_data, d);
    check_regs(req);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; ep_busy = '0;
    do_reset();

    // R1 reset state
    check("R1 strobe", 32'(ep_valid), 32'd0);
    read_reg(8'hB8, v); check("R1 status", v, 32'h4000_0000);
    read_reg(8'hBC, v); check("R1 drop", v, 32'd0);
    // R10 unmapped reads
    read_reg(8'hA0, v); check("R10 read A0", v, 32'd0);
    read_reg(8'h9C, v); check("R10 read 9C", v, 32'd0);

    // R3 direct forward, each window edge and every channel
    do_write("R3 ch0 A0", 8'hA0, 32'h1234_5670, '0);
    do_write("R3 ch8 AC", 8'hAC, 32'hCAFE_0008, '0);
    for (int c = 0; c < NCH; c++)
      do_write("R3 sweep", 8'hA4, {28'hABCDEF0, 4'(c)}, '0);
    // R2 outside the window
    do_write("R2 9F", 8'h9F, 32'h0000_0001, '0);
    do_write("R2 AD", 8'hAD, 32'h0000_0002, '0);
    do_write("R2 B8", 8'hB8, 32'h0000_0003, '1);
    // R5 bad channel and R8 clear
    do_write("R5 ch9", 8'hA8, 32'h0000_0009, '0);
    do_write("R8 clear", 8'hBC, 32'h0, '0);
    do_write("R5 ch15", 8'hA0, 32'hFFFF_FFFF, '1);
    do_write("R8 clear2", 8'hBC, 32'h5, '0);

    // R4 / R6 fill to full then overflow to idle valid channel
    for (int i = 0; i < DEP; i++)
      do_write("R4 fill", 8'hA0, {28'h0, 4'(i)}, '1);
    do_write("R6 full drop", 8'hA4, 32'h0000_0002, '0);
    // R9 words stay while endpoints go idle
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); ep_busy = '0;
    end
    check_regs("R9 hold");
    do_reset();
    check_regs("R9 reset");

    // random phase
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      logic [NCH-1:0] b;
      int sel;
      if (i % 50 == 49) do_reset();
      sel = $urandom_range(0, 9);
      case (sel)
        0: a = 8'hBC;
        1: a = 8'(8'h80 + $urandom_range(0, 127));
        default: a = 8'(8'hA0 + $urandom_range(0, 12));
      endcase
      d = $urandom();
      b = NCH'($urandom()) | NCH'($urandom());
      do_write("R4 random", a, d, b);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule